// File: doc/BRIEF.md
# Sleep and Idle Power Controller

This controller sits beside a small processor core and decides which clock enables stay on while the core is parked in one of two low-power states. A single-cycle power-save request carries a mode bit. With the bit set, the block enters Sleep: the CPU clock, the system oscillator and every peripheral running from the system clock are turned off. With the bit clear, it enters Idle: only the CPU clock stops, and each peripheral keeps running unless its own stop-in-idle bit is set.

On entry to either state the block issues a one-cycle watchdog-clear pulse, but only when the watchdog is enabled. It keeps the low-power RC clock running when the watchdog needs it, or when the clock monitor needs it outside Sleep. It reports whether the clock monitor can work, and it passes the brown-out and low-voltage detector enables straight through. A wake comes from an enabled interrupt or a watchdog timeout, and is marked by a one-cycle pulse with a cause code. A synchronous reset request returns the block to Run without that pulse. Leaving Sleep turns the oscillator back on first, and the CPU clock returns only once the oscillator reports ready.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After rst_n is released, the block is in Run: cpu_clk_en=1, sysosc_en=1, all periph_clk_en bits 1, wdt_clr=0, wake_pulse=0, wake_cause=2'b00.
- R2: A psave_req in Run with psave_mode=1 (Sleep) gives cpu_clk_en=0, sysosc_en=0 and all periph_clk_en bits 0 from the next cycle on.
- R3: A psave_req in Run with psave_mode=0 (Idle) gives cpu_clk_en=0 and sysosc_en=1 from the next cycle on, with periph_clk_en[i] equal to the inverse of stop_in_idle[i].
- R4: On entry to either mode, wdt_clr is high for exactly the first cycle in the mode if wdt_en was 1 at the request, and stays low if wdt_en was 0.
- R5: lprc_en equals wdt_en in Sleep, and equals wdt_en OR fscm_en in every other state.
- R6: fscm_active equals fscm_en, except that it is 0 in Sleep.
- R7: In Idle, an interrupt with irq_src[k]=1 and irq_en[k]=1, or wdt_timeout=1, returns the block to Run (cpu_clk_en=1) in the next cycle. In that same cycle wake_pulse=1 for one cycle, with wake_cause=2'b01 for an interrupt or 2'b10 for a watchdog timeout. The interrupt code wins when both occur together, and wake_cause is 2'b00 whenever wake_pulse is 0.
- R8: An interrupt source whose irq_en bit is 0 does not wake the block: it stays in its mode and wake_pulse stays 0.
- R9: A wake event in Sleep sets sysosc_en=1 and pulses wake_pulse with its cause in the next cycle. cpu_clk_en and the peripheral enables stay 0 until osc_ready is 1, and they turn on in the cycle after osc_ready is seen.
- R10: sys_rst_req=1 in any state returns the block to Run in the next cycle, without a wake_pulse.
- R11: bor_en_out equals bor_en_in and lvd_en_out equals lvd_en_in in every state, including Sleep.
- R12: psave_req has no effect while the block is not in Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psave_req | input | 1 | One-cycle power-save request |
| psave_mode | input | 1 | Mode of the request: 1 Sleep, 0 Idle |
| irq_src | input | N_IRQ | Pending interrupt sources |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| wdt_timeout | input | 1 | Watchdog time-out event |
| sys_rst_req | input | 1 | Synchronous reset request from any reset source |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Clock monitor enabled |
| osc_ready | input | 1 | System oscillator has restarted and is stable |
| stop_in_idle | input | N_PERIPH | Per-peripheral gate-in-Idle controls |
| bor_en_in | input | 1 | Brown-out detector enable |
| lvd_en_in | input | 1 | Low-voltage detector enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| sysosc_en | output | 1 | System oscillator enable |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| lprc_en | output | 1 | Low-power RC clock enable |
| fscm_active | output | 1 | Clock monitor allowed to operate |
| wdt_clr | output | 1 | Watchdog clear pulse |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_cause | output | 2 | Wake cause: 01 interrupt, 10 watchdog, 00 none |
| bor_en_out | output | 1 | Brown-out enable, passed through |
| lvd_en_out | output | 1 | Low-voltage enable, passed through |

## Verification
The assertions assume that psave_req, the wake inputs and sys_rst_req are synchronous to clk, and that osc_ready matters only after the oscillator has been re-enabled. The assertions about the mode enables also assume that stop_in_idle stays still while the block sits in Idle. The directed tasks change every input on the falling edge. They keep stop_in_idle fixed during each Idle stay, raise osc_ready only once the oscillator has come back, and hold each wake or reset input for one cycle at a time unless a test needs two of them together.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [1:0] {
      PST_RUN   = 2'd0,
      PST_IDLE  = 2'd1,
      PST_SLEEP = 2'd2,
      PST_OSCW  = 2'd3
   } pwr_state_t;

   typedef enum logic [1:0] {
      WCAUSE_NONE = 2'b00,
      WCAUSE_IRQ  = 2'b01,
      WCAUSE_WDT  = 2'b10,
      WCAUSE_RST  = 2'b11
   } wake_cause_t;

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
   import pwr_mode_pkg::*;
#(
   parameter int N_IRQ = 8
) (
   input  logic [N_IRQ-1:0] irq_src,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             wdt_timeout,
   output logic             wake_evt,
   output wake_cause_t      wake_code
);

   logic irq_hit;

   assign irq_hit  = |(irq_src & irq_en);
   assign wake_evt = irq_hit | wdt_timeout;

   always_comb begin
      if (irq_hit)          wake_code = WCAUSE_IRQ;
      else if (wdt_timeout) wake_code = WCAUSE_WDT;
      else                  wake_code = WCAUSE_NONE;
   end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        psave_req,
   input  logic        psave_mode,
   input  logic        wake_evt,
   input  wake_cause_t wake_code,
   input  logic        sys_rst_req,
   input  logic        wdt_en,
   input  logic        osc_ready,
   output pwr_state_t  state,
   output logic        wdt_clr,
   output logic        wake_pulse,
   output logic [1:0]  wake_cause
);

   pwr_state_t  state_q;
   logic        clr_q;
   logic        wake_q;
   wake_cause_t cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PST_RUN;
         clr_q   <= 1'b0;
         wake_q  <= 1'b0;
         cause_q <= WCAUSE_NONE;
      end else begin
         clr_q   <= 1'b0;
         wake_q  <= 1'b0;
         cause_q <= WCAUSE_NONE;
         if (sys_rst_req) begin
            state_q <= PST_RUN;
         end else begin
            unique case (state_q)
               PST_RUN: begin
                  if (psave_req) begin
                     state_q <= psave_mode ? PST_SLEEP : PST_IDLE;
                     clr_q   <= wdt_en;
                  end
               end
               PST_IDLE: begin
                  if (wake_evt) begin
                     state_q <= PST_RUN;
                     wake_q  <= 1'b1;
                     cause_q <= wake_code;
                  end
               end
               PST_SLEEP: begin
                  if (wake_evt) begin
                     state_q <= PST_OSCW;
                     wake_q  <= 1'b1;
                     cause_q <= wake_code;
                  end
               end
               PST_OSCW: begin
                  if (osc_ready) state_q <= PST_RUN;
               end
               default: state_q <= PST_RUN;
            endcase
         end
      end
   end

   assign state      = state_q;
   assign wdt_clr    = clr_q;
   assign wake_pulse = wake_q;
   assign wake_cause = cause_q;

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
   import pwr_mode_pkg::*;
#(
   parameter int N_PERIPH             = 4,
   parameter bit STOP_IN_IDLE_SUPPORT = 1'b1
) (
   input  pwr_state_t          state,
   input  logic [N_PERIPH-1:0] stop_in_idle,
   input  logic                wdt_en,
   input  logic                fscm_en,
   output logic                cpu_clk_en,
   output logic                sysosc_en,
   output logic [N_PERIPH-1:0] periph_clk_en,
   output logic                lprc_en,
   output logic                fscm_active
);

   logic in_run;
   logic in_idle;
   logic in_sleep;

   assign in_run   = (state == PST_RUN);
   assign in_idle  = (state == PST_IDLE);
   assign in_sleep = (state == PST_SLEEP);

   assign cpu_clk_en  = in_run;
   assign sysosc_en   = !in_sleep;
   assign fscm_active = fscm_en & !in_sleep;
   assign lprc_en     = in_sleep ? wdt_en : (wdt_en | fscm_en);

   for (genvar p = 0; p < N_PERIPH; p++) begin : g_periph
      if (STOP_IN_IDLE_SUPPORT) begin : g_sid
         assign periph_clk_en[p] = in_run | (in_idle & !stop_in_idle[p]);
      end else begin : g_nosid
         logic unused_sid;
         assign unused_sid       = stop_in_idle[p];
         assign periph_clk_en[p] = in_run | in_idle;
      end
   end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int N_PERIPH             = 4,
   parameter int N_IRQ                = 8,
   parameter bit STOP_IN_IDLE_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                psave_req,
   input  logic                psave_mode,
   input  logic [N_IRQ-1:0]    irq_src,
   input  logic [N_IRQ-1:0]    irq_en,
   input  logic                wdt_timeout,
   input  logic                sys_rst_req,
   input  logic                wdt_en,
   input  logic                fscm_en,
   input  logic                osc_ready,
   input  logic [N_PERIPH-1:0] stop_in_idle,
   input  logic                bor_en_in,
   input  logic                lvd_en_in,
   output logic                cpu_clk_en,
   output logic                sysosc_en,
   output logic [N_PERIPH-1:0] periph_clk_en,
   output logic                lprc_en,
   output logic                fscm_active,
   output logic                wdt_clr,
   output logic                wake_pulse,
   output logic [1:0]          wake_cause,
   output logic                bor_en_out,
   output logic                lvd_en_out
);

   if (N_PERIPH < 1) begin : g_bad_periph
      $error("pwr_mode_ctrl: N_PERIPH must be at least 1");
   end
   if (N_IRQ < 1) begin : g_bad_irq
      $error("pwr_mode_ctrl: N_IRQ must be at least 1");
   end

   logic        wake_evt;
   wake_cause_t wake_code;
   pwr_state_t  state;

   pwr_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
      .irq_src     (irq_src),
      .irq_en      (irq_en),
      .wdt_timeout (wdt_timeout),
      .wake_evt    (wake_evt),
      .wake_code   (wake_code)
   );

   pwr_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .psave_req   (psave_req),
      .psave_mode  (psave_mode),
      .wake_evt    (wake_evt),
      .wake_code   (wake_code),
      .sys_rst_req (sys_rst_req),
      .wdt_en      (wdt_en),
      .osc_ready   (osc_ready),
      .state       (state),
      .wdt_clr     (wdt_clr),
      .wake_pulse  (wake_pulse),
      .wake_cause  (wake_cause)
   );

   pwr_clk_gate #(
      .N_PERIPH             (N_PERIPH),
      .STOP_IN_IDLE_SUPPORT (STOP_IN_IDLE_SUPPORT)
   ) u_gate (
      .state         (state),
      .stop_in_idle  (stop_in_idle),
      .wdt_en        (wdt_en),
      .fscm_en       (fscm_en),
      .cpu_clk_en    (cpu_clk_en),
      .sysosc_en     (sysosc_en),
      .periph_clk_en (periph_clk_en),
      .lprc_en       (lprc_en),
      .fscm_active   (fscm_active)
   );

   assign bor_en_out = bor_en_in;
   assign lvd_en_out = lvd_en_in;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
   parameter int N_PERIPH             = 4,
   parameter int N_IRQ                = 8,
   parameter bit STOP_IN_IDLE_SUPPORT = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                psave_req,
   input logic [N_IRQ-1:0]    irq_src,
   input logic [N_IRQ-1:0]    irq_en,
   input logic                wdt_timeout,
   input logic                sys_rst_req,
   input logic                wdt_en,
   input logic                fscm_en,
   input logic [N_PERIPH-1:0] stop_in_idle,
   input logic                cpu_clk_en,
   input logic                sysosc_en,
   input logic [N_PERIPH-1:0] periph_clk_en,
   input logic                lprc_en,
   input logic                fscm_active,
   input logic                wdt_clr,
   input logic                wake_pulse,
   input logic [1:0]          wake_cause
);

   // R2: with oscillator off, no peripheral clock may run
   a_r2_sleep_periph_off: assert property (@(posedge clk) disable iff (!rst_n)
      !sysosc_en |-> (periph_clk_en == '0));

   // R3: a peripheral with its stop bit set never runs while the CPU is parked
   a_r3_stop_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (STOP_IN_IDLE_SUPPORT && sysosc_en && !cpu_clk_en) |-> ((periph_clk_en & stop_in_idle) == '0));

   // R4: the watchdog clear is a single cycle and only with the watchdog on
   a_r4_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |=> !wdt_clr);
   a_r4_clr_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |-> (!cpu_clk_en && $past(psave_req) && $past(wdt_en)));

   // R5: in Sleep the RC clock follows the watchdog enable alone
   a_r5_lprc_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      !sysosc_en |-> (lprc_en == wdt_en));

   // R6: clock monitor stopped while the oscillator is off
   a_r6_fscm_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      !sysosc_en |-> !fscm_active);
   a_r6_fscm_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      fscm_active |-> fscm_en);

   // R7: wake pulse lasts one cycle and carries an interrupt or watchdog code
   a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);
   a_r7_cause_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (wake_cause == 2'b01 || wake_cause == 2'b10));
   a_r7_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_pulse |-> (wake_cause == 2'b00));
   a_r7_wake_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> ($past(wdt_timeout) || $past((irq_src & irq_en) != '0)));

   // R10: a reset request lands in Run with no wake pulse
   a_r10_reset_to_run: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |=> (cpu_clk_en && sysosc_en && !wake_pulse));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
   .N_PERIPH             (N_PERIPH),
   .N_IRQ                (N_IRQ),
   .STOP_IN_IDLE_SUPPORT (STOP_IN_IDLE_SUPPORT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .psave_req     (psave_req),
   .irq_src       (irq_src),
   .irq_en        (irq_en),
   .wdt_timeout   (wdt_timeout),
   .sys_rst_req   (sys_rst_req),
   .wdt_en        (wdt_en),
   .fscm_en       (fscm_en),
   .stop_in_idle  (stop_in_idle),
   .cpu_clk_en    (cpu_clk_en),
   .sysosc_en     (sysosc_en),
   .periph_clk_en (periph_clk_en),
   .lprc_en       (lprc_en),
   .fscm_active   (fscm_active),
   .wdt_clr       (wdt_clr),
   .wake_pulse    (wake_pulse),
   .wake_cause    (wake_cause)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;

   localparam int NP = 4;
   localparam int NI = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          psave_req, psave_mode, wdt_timeout, sys_rst_req;
   logic          wdt_en, fscm_en, osc_ready, bor_en_in, lvd_en_in;
   logic [NI-1:0] irq_src, irq_en;
   logic [NP-1:0] stop_in_idle;
   logic          cpu_clk_en, sysosc_en, lprc_en, fscm_active, wdt_clr, wake_pulse;
   logic          bor_en_out, lvd_en_out;
   logic [NP-1:0] periph_clk_en;
   logic [1:0]    wake_cause;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pwr_mode_ctrl #(.N_PERIPH(NP), .N_IRQ(NI)) uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic enter(input logic mode);
      psave_req  = 1'b1;
      psave_mode = mode;
      tick();
      psave_req  = 1'b0;
   endtask

   // back to Run through a reset request
   task automatic to_run();
      sys_rst_req = 1'b1;
      tick();
      sys_rst_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cpu", cpu_clk_en, 1);
      chk("R1 osc", sysosc_en, 1);
      chk("R1 periph", periph_clk_en, 4'hF);
      chk("R1 clr/wake/cause", {wdt_clr, wake_pulse, wake_cause}, 0);
   endtask

   task automatic t_sleep_gates();
      wdt_en = 1'b0; fscm_en = 1'b1;
      enter(1'b1);
      chk("R2 cpu", cpu_clk_en, 0);
      chk("R2 osc", sysosc_en, 0);
      chk("R2 periph", periph_clk_en, 0);
      chk("R4 no clr when wdt off", wdt_clr, 0);
      chk("R5 lprc sleep wdt off", lprc_en, 0);
      chk("R6 fscm off in sleep", fscm_active, 0);
      to_run();
   endtask

   task automatic t_idle_gates();
      stop_in_idle = 4'b1010; wdt_en = 1'b1; fscm_en = 1'b0;
      enter(1'b0);
      chk("R3 cpu", cpu_clk_en, 0);
      chk("R3 osc", sysosc_en, 1);
      chk("R3 periph", periph_clk_en, 4'b0101);
      chk("R4 clr first cycle", wdt_clr, 1);
      chk("R5 lprc idle", lprc_en, 1);
      tick();
      chk("R4 clr single", wdt_clr, 0);
      wdt_en = 1'b0; fscm_en = 1'b1;
      tick();
      chk("R5 lprc idle fscm", lprc_en, 1);
      chk("R6 fscm idle", fscm_active, 1);
      fscm_en = 1'b0;
      tick();
      chk("R5 lprc idle none", lprc_en, 0);
      to_run();
      stop_in_idle = 4'b0000;
   endtask

   task automatic t_sleep_lprc_wdt();
      wdt_en = 1'b1; fscm_en = 1'b1;
      enter(1'b1);
      chk("R4 clr on sleep entry", wdt_clr, 1);
      chk("R5 lprc sleep wdt on", lprc_en, 1);
      tick();
      chk("R4 clr single sleep", wdt_clr, 0);
      to_run();
      wdt_en = 1'b0; fscm_en = 1'b0;
   endtask

   task automatic t_idle_wake_irq();
      enter(1'b0);
      irq_src = 8'h10; irq_en = 8'h10;
      tick();
      irq_src = '0;
      chk("R7 irq wake cpu", cpu_clk_en, 1);
      chk("R7 irq wake pulse", wake_pulse, 1);
      chk("R7 irq cause", wake_cause, 2'b01);
      tick();
      chk("R7 pulse single", wake_pulse, 0);
      chk("R7 cause cleared", wake_cause, 0);
   endtask

   task automatic t_idle_wake_both();
      enter(1'b0);
      wdt_timeout = 1'b1;
      tick();
      wdt_timeout = 1'b0;
      chk("R7 wdt cause", {cpu_clk_en, wake_pulse, wake_cause}, 4'b1110);
      enter(1'b0);
      wdt_timeout = 1'b1; irq_src = 8'h01; irq_en = 8'h01;
      tick();
      wdt_timeout = 1'b0; irq_src = '0;
      chk("R7 irq priority", wake_cause, 2'b01);
   endtask

   task automatic t_masked_irq();
      enter(1'b0);
      irq_src = 8'h82; irq_en = 8'h7D;
      tick();
      tick();
      chk("R8 masked stays idle", cpu_clk_en, 0);
      chk("R8 masked no pulse", wake_pulse, 0);
      irq_src = '0;
      to_run();
   endtask

   task automatic t_sleep_wake();
      osc_ready = 1'b0;
      enter(1'b1);
      irq_src = 8'h04; irq_en = 8'h04;
      tick();
      irq_src = '0;
      chk("R9 osc back", sysosc_en, 1);
      chk("R9 cpu held", cpu_clk_en, 0);
      chk("R9 periph held", periph_clk_en, 0);
      chk("R9 pulse cause", {wake_pulse, wake_cause}, 3'b101);
      tick(); tick();
      chk("R9 cpu still held", cpu_clk_en, 0);
      osc_ready = 1'b1;
      tick();
      chk("R9 cpu after ready", cpu_clk_en, 1);
      chk("R9 periph after ready", periph_clk_en, 4'hF);
      osc_ready = 1'b0;
   endtask

   task automatic t_sys_rst();
      enter(1'b1);
      sys_rst_req = 1'b1; irq_src = 8'h01; irq_en = 8'h01;
      tick();
      sys_rst_req = 1'b0; irq_src = '0;
      chk("R10 run from sleep", {cpu_clk_en, sysosc_en}, 2'b11);
      chk("R10 no pulse", wake_pulse, 0);
      enter(1'b0);
      to_run();
      chk("R10 run from idle", {cpu_clk_en, wake_pulse}, 2'b10);
   endtask

   task automatic t_passthru();
      bor_en_in = 1'b1; lvd_en_in = 1'b0;
      enter(1'b1);
      chk("R11 sleep pass", {bor_en_out, lvd_en_out}, 2'b10);
      bor_en_in = 1'b0; lvd_en_in = 1'b1;
      tick();
      chk("R11 sleep pass swap", {bor_en_out, lvd_en_out}, 2'b01);
      to_run();
   endtask

   task automatic t_req_ignored();
      stop_in_idle = 4'b0011;
      enter(1'b0);
      enter(1'b1);
      chk("R12 stays idle osc", sysosc_en, 1);
      chk("R12 stays idle periph", periph_clk_en, 4'b1100);
      to_run();
      stop_in_idle = 4'b0000;
   endtask

   initial begin
      rst_n = 1'b0; psave_req = 0; psave_mode = 0; wdt_timeout = 0; sys_rst_req = 0;
      wdt_en = 0; fscm_en = 0; osc_ready = 0; bor_en_in = 0; lvd_en_in = 0;
      irq_src = '0; irq_en = '0; stop_in_idle = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_sleep_gates();
      t_idle_gates();
      t_sleep_lprc_wdt();
      t_idle_wake_irq();
      t_idle_wake_both();
      t_masked_irq();
      t_sleep_wake();
      t_sys_rst();
      t_passthru();
      t_req_ignored();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule